// File: doc/BRIEF.md
# Slow-Clock System Timer with Absolute Alarm

This block is a small system timer for a chip's always-on region. A one-cycle enable pulse, `slck_en`, marks each tick of a 32768 Hz slow clock in the host clock domain. A programmable prescaler divides these ticks and advances a free-running real-time counter. The counter wraps modulo 2^CNT_W, and CNT_W is 20 by default. An alarm comparator holds an absolute counter value. It raises a flag when the counter steps onto that value. A separate interval timer raises a flag once every N slow ticks, where N is a programmed period.

Four event flags are latched in a status register: periodic tick, alarm match, counter increment and watchdog overflow. Software sees them through a synchronous register port, and a read of the status register clears them. Software sets mask bits through an enable strobe register and clears them through a disable strobe register. One interrupt line is driven from the flags that are both set and enabled. Watchdog reset generation and clock-domain crossing are outside this block; the watchdog is only a pulse input that sets its flag.

Top module: `sys_timer_top`

## Requirements
- R1: The real-time counter is CNT_W bits wide. It changes only when the prescaler fires, steps by one, and goes from all ones to zero.
- R2: With prescale value P, the counter advances once every P slow ticks. P = 1 advances it on every tick, and P = 0 acts as 2^DIV_W. Writing the prescale register restarts the division from zero.
- R3: After reset the prescale register holds 32768, so the counter advances once per second. Counter, alarm, period, status and mask read 0, and `irq` is low.
- R4: Status bit 1 (alarm) sets in the cycle after the counter advances to a value equal to the alarm register.
- R5: If the alarm is written with the value the counter already holds, no alarm flag appears until the counter has advanced 2^CNT_W times.
- R6: With period N, status bit 0 (periodic) sets once every N slow ticks. N = 0 acts as 2^DIV_W.
- R7: Writing the period register restarts the interval count, so the next periodic flag comes N slow ticks after the write.
- R8: Status bit 2 sets on every counter advance. A one-cycle pulse on `wdog_ovf` sets status bit 3.
- R9: A status read returns the flags as held before the read and clears them. A flag whose event falls in the same cycle as the read stays set.
- R10: Writing the enable address (1) sets each mask bit where wdata has a one. Writing the disable address (2) clears each mask bit where wdata has a one. Other mask bits are left alone.
- R11: `irq` is high exactly when some status bit and its mask bit are both set.
- R12: Register addresses are 0 status, 1 enable, 2 disable, 3 mask, 4 period, 5 prescale, 6 alarm and 7 counter. `rdata` is valid in the cycle after `rd_en`. Addresses 1 and 2 read as 0, and writes to 0, 3 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| slck_en | input | 1 | One-cycle pulse per slow-clock tick |
| wdog_ovf | input | 1 | Watchdog overflow event pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | BUS_W | Write data (widest register) |
| rdata | output | BUS_W | Read data, registered |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench targets the counter wrap. A design that compared the alarm against the old counter value, or against a value that is not current, would fire at once when the alarm is written with the current count, instead of waiting out the full 2^CNT_W advances. It also places a status read and a new event in the same cycle; a design that let the clear win there would lose the event for good. It also exercises a period or prescale write mid-count and the zero values that stand for 2^DIV_W; a design that kept the old count, or stuck or fired every tick on zero, would put the flags at the wrong tick.

// File: rtl/st_pkg.sv
package st_pkg;

    localparam int FLAG_N = 4;

    typedef enum logic [2:0] {
        RA_STATUS   = 3'd0,
        RA_IEN      = 3'd1,
        RA_IDIS     = 3'd2,
        RA_MASK     = 3'd3,
        RA_PERIOD   = 3'd4,
        RA_PRESCALE = 3'd5,
        RA_ALARM    = 3'd6,
        RA_COUNT    = 3'd7
    } reg_addr_e;

    // bit 0 periodic, bit 1 alarm, bit 2 counter increment, bit 3 watchdog
    typedef struct packed {
        logic wdog;
        logic rt_inc;
        logic alarm;
        logic tick;
    } flags_t;

    function automatic logic [FLAG_N-1:0] flags_bits(flags_t f);
        return {f.wdog, f.rt_inc, f.alarm, f.tick};
    endfunction

endpackage

// File: rtl/st_divider.sv
module st_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         fire
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + W'(1);
    // a limit of zero matches after the count wraps: one fire per 2^W ticks
    assign fire    = tick && !restart && (cnt_inc == limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= fire ? '0 : cnt_inc;
        end
    end
endmodule

// File: rtl/st_rtc.sv
module st_rtc #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] alarm,
    output logic [W-1:0] count,
    output logic         hit
);
    logic [W-1:0] next_val;

    assign next_val = count + W'(1);
    // the match is taken on the value being stepped onto, never the held one
    assign hit      = adv && (next_val == alarm);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (adv) begin
            count <= next_val;
        end
    end
endmodule

// File: rtl/sys_timer_top.sv
module sys_timer_top #(
    parameter  int CNT_W        = 20,
    parameter  int DIV_W        = 16,
    parameter  int PRESCALE_RST = 32768,
    localparam int BUS_W        = (CNT_W > DIV_W) ? CNT_W : DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slck_en,
    input  logic             wdog_ovf,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq
);
    import st_pkg::*;

    reg_addr_e          ra;
    logic [DIV_W-1:0]   period_q;
    logic [DIV_W-1:0]   prescale_q;
    logic [CNT_W-1:0]   alarm_q;
    logic [CNT_W-1:0]   rt_count;
    logic [FLAG_N-1:0]  status_q;
    logic [FLAG_N-1:0]  mask_q;
    logic               rt_adv;
    logic               alm_hit;
    logic               pit_fire;
    logic               wr_period;
    logic               wr_prescale;
    logic               rd_status;
    flags_t             ev;

    assign ra          = reg_addr_e'(addr);
    assign wr_period   = wr_en && (ra == RA_PERIOD);
    assign wr_prescale = wr_en && (ra == RA_PRESCALE);
    assign rd_status   = rd_en && (ra == RA_STATUS);

    st_divider #(.W(DIV_W)) prescaler_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (slck_en),
        .restart (wr_prescale),
        .limit   (prescale_q),
        .fire    (rt_adv)
    );

    st_divider #(.W(DIV_W)) interval_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (slck_en),
        .restart (wr_period),
        .limit   (period_q),
        .fire    (pit_fire)
    );

    st_rtc #(.W(CNT_W)) rtc_i (
        .clk   (clk),
        .rst   (rst),
        .adv   (rt_adv),
        .alarm (alarm_q),
        .count (rt_count),
        .hit   (alm_hit)
    );

    always_comb begin
        ev.tick   = pit_fire;
        ev.alarm  = alm_hit;
        ev.rt_inc = rt_adv;
        ev.wdog   = wdog_ovf;
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            period_q   <= '0;
            prescale_q <= DIV_W'(PRESCALE_RST);
            alarm_q    <= '0;
        end else if (wr_en) begin
            case (ra)
                RA_PERIOD:   period_q   <= wdata[DIV_W-1:0];
                RA_PRESCALE: prescale_q <= wdata[DIV_W-1:0];
                RA_ALARM:    alarm_q    <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // status: a fresh event is ORed in after the read clear, so it survives
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= (rd_status ? '0 : status_q) | flags_bits(ev);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_en && (ra == RA_IEN)) begin
            mask_q <= mask_q | wdata[FLAG_N-1:0];
        end else if (wr_en && (ra == RA_IDIS)) begin
            mask_q <= mask_q & ~wdata[FLAG_N-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (ra)
                RA_STATUS:   rdata <= BUS_W'(status_q);
                RA_MASK:     rdata <= BUS_W'(mask_q);
                RA_PERIOD:   rdata <= BUS_W'(period_q);
                RA_PRESCALE: rdata <= BUS_W'(prescale_q);
                RA_ALARM:    rdata <= BUS_W'(alarm_q);
                RA_COUNT:    rdata <= BUS_W'(rt_count);
                default:     rdata <= '0;
            endcase
        end
    end

    assign irq = |(status_q & mask_q);

endmodule

// File: rtl/st_checker.sv
module st_checker #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [3:0]       wflags,
    input logic [3:0]       status,
    input logic [3:0]       mask,
    input logic             irq,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] alarm,
    input logic             rt_adv,
    input logic             pit_fire,
    input logic             wdog
);
    a_r1_count_holds: assert property (@(posedge clk) disable iff (rst)
        !rt_adv |=> $stable(count));

    a_r1_count_wraps: assert property (@(posedge clk) disable iff (rst)
        (rt_adv && (count == {CNT_W{1'b1}})) |=> (count == '0));

    a_r4_alarm_flag: assert property (@(posedge clk) disable iff (rst)
        (rt_adv && (CNT_W'(count + 1'b1) == alarm)) |=> status[1]);

    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == 3'd0) && !rt_adv && !pit_fire && !wdog) |=> (status == 4'b0));

    a_r10_enable_sets: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == 3'd1)) |=> ((mask & $past(wflags)) == $past(wflags)));

    a_r10_disable_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == 3'd2)) |=> ((mask & $past(wflags)) == 4'b0));

    a_r11_quiet_when_masked: assert property (@(posedge clk) disable iff (rst)
        (mask == 4'b0) |-> !irq);

endmodule

bind sys_timer_top st_checker #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wflags   (wdata[3:0]),
    .status   (status_q),
    .mask     (mask_q),
    .irq      (irq),
    .count    (rt_count),
    .alarm    (alarm_q),
    .rt_adv   (rt_adv),
    .pit_fire (pit_fire),
    .wdog     (wdog_ovf)
);

// File: tb/sys_timer_top_tb_top.sv
`timescale 1ns/1ps
module sys_timer_top_tb_top;
    localparam int CNT_W = 10;
    localparam int DIV_W = 16;
    localparam int BUS_W = (CNT_W > DIV_W) ? CNT_W : DIV_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             slck_en = 1'b0;
    logic             wdog_ovf = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [2:0]       addr = '0;
    logic [BUS_W-1:0] wdata = '0;
    logic [BUS_W-1:0] rdata;
    logic             irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state, built from the requirements
    logic [CNT_W-1:0] m_cnt = '0;
    logic [CNT_W-1:0] m_alarm = '0;
    logic [DIV_W-1:0] m_per = '0;
    logic [DIV_W-1:0] m_pre = 16'd32768;
    logic [DIV_W-1:0] m_pitc = '0;
    logic [DIV_W-1:0] m_prec = '0;
    logic [3:0]       m_stat = '0;
    logic [3:0]       m_mask = '0;

    always #2.5 clk = ~clk;

    sys_timer_top #(.CNT_W(CNT_W), .DIV_W(DIV_W), .PRESCALE_RST(32768)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .slck_en  (slck_en),
        .wdog_ovf (wdog_ovf),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .irq      (irq)
    );

    function automatic string req_of(logic [2:0] a);
        case (a)
            3'd0:    return "R9";
            3'd3:    return "R10";
            3'd4:    return "R6";
            3'd5:    return "R2";
            3'd6:    return "R4";
            3'd7:    return "R1";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one host cycle: drive, advance reference at the edge, compare after it
    task automatic step(input logic s, input logic w, input logic r,
                        input logic [2:0] a, input logic [BUS_W-1:0] d,
                        input logic wd);
        logic [3:0]       ev;
        logic             adv;
        logic [BUS_W-1:0] rd_v;
        logic [DIV_W-1:0] nx;
        logic [CNT_W-1:0] nc;
        slck_en = s; wr_en = w; rd_en = r; addr = a; wdata = d; wdog_ovf = wd;
        ev = '0; adv = 1'b0; rd_v = '0;
        case (a)
            3'd0: rd_v = BUS_W'(m_stat);
            3'd3: rd_v = BUS_W'(m_mask);
            3'd4: rd_v = BUS_W'(m_per);
            3'd5: rd_v = BUS_W'(m_pre);
            3'd6: rd_v = BUS_W'(m_alarm);
            3'd7: rd_v = BUS_W'(m_cnt);
            default: rd_v = '0;
        endcase
        @(posedge clk);
        if (w && a == 3'd4) m_pitc = '0;
        else if (s) begin
            nx = m_pitc + 16'd1;
            if (nx == m_per) begin ev[0] = 1'b1; m_pitc = '0; end
            else m_pitc = nx;
        end
        if (w && a == 3'd5) m_prec = '0;
        else if (s) begin
            nx = m_prec + 16'd1;
            if (nx == m_pre) begin adv = 1'b1; m_prec = '0; end
            else m_prec = nx;
        end
        if (adv) begin
            ev[2] = 1'b1;
            nc = m_cnt + 1'b1;
            if (nc == m_alarm) ev[1] = 1'b1;
            m_cnt = nc;
        end
        ev[3] = wd;
        m_stat = ((r && a == 3'd0) ? 4'b0 : m_stat) | ev;
        if (w) begin
            case (a)
                3'd1: m_mask = m_mask | d[3:0];
                3'd2: m_mask = m_mask & ~d[3:0];
                3'd4: m_per = d[DIV_W-1:0];
                3'd5: m_pre = d[DIV_W-1:0];
                3'd6: m_alarm = d[CNT_W-1:0];
                default: ;
            endcase
        end
        @(negedge clk);
        slck_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wdog_ovf = 1'b0;
        chk("R11 irq", 32'(irq), 32'(|(m_stat & m_mask)));
        if (r) chk(req_of(a), 32'(rdata), 32'(rd_v));
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 3'd0, '0, 1'b0);
    endtask

    task automatic wr(logic [2:0] a, logic [BUS_W-1:0] d);
        step(1'b0, 1'b1, 1'b0, a, d, 1'b0);
    endtask

    task automatic rd(logic [2:0] a, output logic [BUS_W-1:0] v);
        step(1'b0, 1'b0, 1'b1, a, '0, 1'b0);
        v = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [BUS_W-1:0] v;
        logic [CNT_W-1:0] c;
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R3 reset values
        chk("R3 irq", 32'(irq), 0);
        rd(3'd0, v); chk("R3 status", 32'(v), 0);
        rd(3'd3, v); chk("R3 mask", 32'(v), 0);
        rd(3'd4, v); chk("R3 period", 32'(v), 0);
        rd(3'd5, v); chk("R3 prescale", 32'(v), 32768);
        rd(3'd6, v); chk("R3 alarm", 32'(v), 0);
        rd(3'd7, v); chk("R3 count", 32'(v), 0);
        rd(3'd1, v); chk("R12 enable reads zero", 32'(v), 0);

        // R3 one advance per 32768 ticks; R8 increment flag
        ticks(32767);
        rd(3'd7, v); chk("R3 count before second", 32'(v), 0);
        ticks(1);
        rd(3'd7, v); chk("R3 count after second", 32'(v), 1);
        rd(3'd0, v); chk("R8 increment flag", 32'(v), 4'b0100);

        // R2 and R6: zero prescale and zero period act as 2^16
        wr(3'd5, 0);
        wr(3'd4, 0);
        wr(3'd1, 16'h1);
        ticks(65535);
        rd(3'd7, v); chk("R2 zero prescale holds", 32'(v), 1);
        rd(3'd0, v); chk("R6 zero period quiet", 32'(v), 0);
        ticks(1);
        chk("R11 irq on periodic", 32'(irq), 1);
        rd(3'd7, v); chk("R2 zero prescale fires", 32'(v), 2);
        rd(3'd0, v); chk("R6 zero period fires", 32'(v), 4'b0101);
        chk("R11 irq after clear", 32'(irq), 0);

        // R7 period write restarts the interval count
        wr(3'd5, 1);
        wr(3'd4, 5);
        ticks(4);
        rd(3'd0, v); chk("R7 no tick yet", 32'(v[0]), 0);
        ticks(1);
        rd(3'd0, v); chk("R6 tick at five", 32'(v[0]), 1);
        ticks(3);
        wr(3'd4, 5);
        ticks(4);
        rd(3'd0, v); chk("R7 restart delays tick", 32'(v[0]), 0);
        ticks(1);
        rd(3'd0, v); chk("R7 tick after restart", 32'(v[0]), 1);

        // R4 absolute alarm
        rd(3'd7, v); c = v[CNT_W-1:0];
        wr(3'd6, BUS_W'(CNT_W'(c + 3)));
        ticks(2);
        rd(3'd0, v); chk("R4 alarm not yet", 32'(v[1]), 0);
        ticks(1);
        rd(3'd0, v); chk("R4 alarm match", 32'(v[1]), 1);

        // R5 alarm equal to current count waits a full wrap; R1 wrap
        rd(3'd7, v); c = v[CNT_W-1:0];
        wr(3'd6, BUS_W'(c));
        rd(3'd0, v);
        ticks((1 << CNT_W) - 1);
        rd(3'd0, v); chk("R5 no early alarm", 32'(v[1]), 0);
        ticks(1);
        rd(3'd0, v); chk("R5 alarm after wrap", 32'(v[1]), 1);
        rd(3'd7, v); chk("R1 counter wrapped", 32'(v), 32'(c));

        // R9 event in the same cycle as the status read survives
        step(1'b1, 1'b0, 1'b1, 3'd0, '0, 1'b0);
        rd(3'd0, v); chk("R9 same-cycle event kept", 32'(v[2]), 1);

        // R8 watchdog flag
        step(1'b0, 1'b0, 1'b0, 3'd0, '0, 1'b1);
        rd(3'd0, v); chk("R8 watchdog flag", 32'(v), 4'b1000);

        // R10 mask strobes
        wr(3'd1, 16'hF);
        wr(3'd2, 16'h5);
        rd(3'd3, v); chk("R10 disable", 32'(v), 4'hA);
        wr(3'd1, 16'h1);
        rd(3'd3, v); chk("R10 enable", 32'(v), 4'hB);
        wr(3'd3, 16'h0);
        rd(3'd3, v); chk("R12 mask read-only", 32'(v), 4'hB);

        // R11 masked flags keep irq low
        wr(3'd2, 16'hF);
        ticks(1);
        chk("R11 irq masked", 32'(irq), 0);
        rd(3'd0, v); chk("R11 flag pending", 32'(v[2]), 1);

        // mixed random traffic against the reference
        for (int i = 0; i < 15000; i++) begin
            int op;
            logic [2:0] a;
            logic [BUS_W-1:0] d;
            logic s;
            op = $urandom_range(0, 9);
            s  = ($urandom_range(0, 1) == 1);
            a  = 3'($urandom_range(0, 7));
            d  = BUS_W'($urandom());
            case (a)
                3'd4: d = BUS_W'($urandom_range(1, 7));
                3'd5: d = BUS_W'($urandom_range(1, 3));
                3'd6: d = BUS_W'(CNT_W'(m_cnt + $urandom_range(1, 20)));
                default: ;
            endcase
            if (op < 5)       step(s, 1'b0, 1'b0, a, d, 1'b0);
            else if (op < 7)  step(s, 1'b1, 1'b0, a, d, 1'b0);
            else if (op < 9)  step(s, 1'b0, 1'b1, a, d, 1'b0);
            else              step(s, 1'b0, 1'b0, a, d, 1'b1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule